// File: doc/BRIEF.md
# Baud Rate Tick Generator

This block derives the timing strobes of a serial port from the system clock. An 8-bit divisor X is stored in a register and sets a reload timer that fires once every X+1 clocks. Two divide stages follow the timer. The first stage produces an oversample tick. The second stage turns that into a bit tick, which is one clock wide and marks each serial bit period. The serial shifters that sit next to the block use both strobes as clock enables.

Three rate modes are available. In asynchronous low-speed mode, a bit lasts 64(X+1) clocks. In asynchronous high-speed mode, a bit lasts 16(X+1) clocks. In synchronous master mode, a shift clock period lasts 4(X+1) clocks, and the oversample tick then gives its four quarter phases.

A write to the divisor restarts every counter at once, so the new rate takes effect immediately. In synchronous mode the generator stays idle while the run enable is low. When the run enable rises, the generator emits a shift-clock edge in that same cycle.

Top module: `brg_top`

## Requirements
- R1: While reset is asserted with asynchronous low-speed selected, both os_tick and bit_tick stay low.
- R2: Asynchronous low speed (sync_mode=0, high_speed=0): os_tick repeats every 4(X+1) clocks and bit_tick every 64(X+1) clocks; 16 oversample ticks fall in each bit period.
- R3: Asynchronous high speed (sync_mode=0, high_speed=1): os_tick repeats every X+1 clocks and bit_tick every 16(X+1) clocks.
- R4: Synchronous mode (sync_mode=1, run_en=1): os_tick repeats every X+1 clocks and bit_tick every 4(X+1) clocks, whatever the value of high_speed.
- R5: A write (div_wr=1 at a rising edge) restarts the counters. Counting the cycle that begins at that edge as cycle 0, the first os_tick comes in cycle OSP-1 and the first bit_tick in cycle P-1, where OSP is the oversample period and P is the bit period of the selected mode.
- R6: While sync_mode=1 and run_en=0, neither tick is ever asserted.
- R7: In synchronous mode, os_tick and bit_tick are both high in the first cycle with run_en=1 after an idle cycle. The next bit_tick follows 4(X+1) cycles later.
- R8: bit_tick is only asserted in a cycle in which os_tick is also asserted.
- R9: In asynchronous mode, run_en has no effect and the ticks keep running with run_en=0.
- R10: Every divisor value from 0 through 255 gives the rate stated for its mode, including both end values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_wr | input | 1 | Divisor write strobe |
| div_wdata | input | DIV_W | New divisor value X |
| sync_mode | input | 1 | 1 = synchronous master mode, 0 = asynchronous |
| high_speed | input | 1 | Asynchronous only: 1 = 16 clocks per bit per unit of X+1, 0 = 64 |
| run_en | input | 1 | Synchronous run enable (OR of the transfer enables) |
| os_tick | output | 1 | Oversample / quarter-phase strobe, one cycle wide |
| bit_tick | output | 1 | Bit-rate strobe, one cycle wide |

## Verification
Both ticks are decoded combinationally from registered counters. A divisor write therefore shows its result in the cycle that starts at the write edge plus P-1, with P the bit period. The start of a synchronous run shows in the very cycle in which run_en is first high, with no register delay. The bench changes inputs one time unit after a rising edge and samples on the falling edge. It numbers cycles from the first falling edge after the write edge, so the expected index of the first tick is exactly P-1, or OSP-1 for the oversample tick. The bench computes the expected periods from its own mode formulas and compares the index of every observed tick with them.

// File: rtl/brg_pkg.sv
package brg_pkg;

  // Oversample divide applied to timer pulses in asynchronous low speed
  localparam int OS_DIV_LO   = 4;
  // Oversample ticks per asynchronous bit
  localparam int OVERSAMPLE  = 16;
  // Quarter phases per synchronous shift clock
  localparam int SYNC_PHASES = 4;

  typedef enum logic [1:0] {
    RM_ASYNC_LO = 2'd0,
    RM_ASYNC_HI = 2'd1,
    RM_SYNC     = 2'd2
  } rate_mode_e;

  function automatic rate_mode_e rate_mode(input logic sync_sel, input logic fast_sel);
    rate_mode_e m;
    if (sync_sel)      m = RM_SYNC;
    else if (fast_sel) m = RM_ASYNC_HI;
    else               m = RM_ASYNC_LO;
    return m;
  endfunction

  // Timer pulses per oversample tick
  function automatic int unsigned os_div(input rate_mode_e m);
    return (m == RM_ASYNC_LO) ? OS_DIV_LO : 1;
  endfunction

  // Oversample ticks per bit tick
  function automatic int unsigned bit_div(input rate_mode_e m);
    return (m == RM_SYNC) ? SYNC_PHASES : OVERSAMPLE;
  endfunction

endpackage

// File: rtl/brg_reload_timer.sv
module brg_reload_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         pulse
);

  logic [W-1:0] rl_q;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rl_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (load) rl_q <= load_val;
      if (hold)              cnt_q <= '0;
      else if (load)         cnt_q <= load_val;
      else if (cnt_q == '0)  cnt_q <= rl_q;
      else                   cnt_q <= cnt_q - W'(1);
    end
  end

  assign pulse = !hold && (cnt_q == '0);

  // R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= rl_q);

  // R2
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !load && !hold) |=> (cnt_q == rl_q));

  // R5
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !hold) |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/brg_prescaler.sv
module brg_prescaler #(
  parameter  int LIM_MAX = 16,
  localparam int CW      = $clog2(LIM_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          clear,
  input  logic          in_tick,
  input  logic [CW-1:0] lim,
  output logic          out_tick
);

  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end   = (cnt_q >= lim - CW'(1));
  assign out_tick = in_tick && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (hold)     cnt_q <= lim - CW'(1);
    else if (clear)    cnt_q <= '0;
    else if (in_tick)  cnt_q <= at_end ? '0 : cnt_q + CW'(1);
  end

  // R8
  tick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_tick |-> in_tick);

  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !hold) |=> (cnt_q == '0));

endmodule

// File: rtl/brg_top.sv
module brg_top
  import brg_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  input  logic             sync_mode,
  input  logic             high_speed,
  input  logic             run_en,
  output logic             os_tick,
  output logic             bit_tick
);

  localparam int OS_MAX  = OS_DIV_LO;
  localparam int BIT_MAX = (OVERSAMPLE > SYNC_PHASES) ? OVERSAMPLE : SYNC_PHASES;
  localparam int OS_CW   = $clog2(OS_MAX + 1);
  localparam int BIT_CW  = $clog2(BIT_MAX + 1);

  rate_mode_e        mode;
  logic              hold;
  logic              timer_pulse;
  logic [OS_CW-1:0]  os_lim;
  logic [BIT_CW-1:0] bit_lim;

  always_comb begin
    mode    = rate_mode(sync_mode, high_speed);
    os_lim  = OS_CW'(os_div(mode));
    bit_lim = BIT_CW'(bit_div(mode));
  end

  // Synchronous mode idles until a transfer enable is set
  assign hold = sync_mode && !run_en;

  brg_reload_timer #(.W(DIV_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (hold),
    .load     (div_wr),
    .load_val (div_wdata),
    .pulse    (timer_pulse)
  );

  brg_prescaler #(.LIM_MAX(OS_MAX)) u_os_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (hold),
    .clear    (div_wr),
    .in_tick  (timer_pulse),
    .lim      (os_lim),
    .out_tick (os_tick)
  );

  brg_prescaler #(.LIM_MAX(BIT_MAX)) u_bit_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (hold),
    .clear    (div_wr),
    .in_tick  (os_tick),
    .lim      (bit_lim),
    .out_tick (bit_tick)
  );

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (!os_tick && !bit_tick));

  // R7
  start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && run_en && $past(hold) && $past(rst_n)) |-> (os_tick && bit_tick));

  // R3
  fast_os_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_pulse && (high_speed || sync_mode)) |-> os_tick);

  // R2
  bit_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);

  // R8
  bit_in_os_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> os_tick);

endmodule

// File: tb/brg_top_bench.sv
`timescale 1ns/1ps
module brg_top_bench;

  localparam int DIV_W = 8;
  localparam int WATCHDOG_CYCLES = 180000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             div_wr = 1'b0;
  logic [DIV_W-1:0] div_wdata = '0;
  logic             sync_mode = 1'b0;
  logic             high_speed = 1'b0;
  logic             run_en = 1'b0;
  logic             os_tick;
  logic             bit_tick;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  brg_top #(.DIV_W(DIV_W)) u_brg_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .div_wr     (div_wr),
    .div_wdata  (div_wdata),
    .sync_mode  (sync_mode),
    .high_speed (high_speed),
    .run_en     (run_en),
    .os_tick    (os_tick),
    .bit_tick   (bit_tick)
  );

  // Bit period from the mode formulas
  function automatic int exp_bit_period(input int x, input bit sy, input bit hs);
    int mult;
    if (sy)      mult = 4;
    else if (hs) mult = 16;
    else         mult = 64;
    return mult * (x + 1);
  endfunction

  function automatic int exp_os_period(input int x, input bit sy, input bit hs);
    return (!sy && !hs) ? 4 * (x + 1) : (x + 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_trial(input int x, input bit sy, input bit hs, input bit run);
    int p, osp, first_bit, second_bit, first_os, os_cnt, mism;
    string rq;
    p   = exp_bit_period(x, sy, hs);
    osp = exp_os_period(x, sy, hs);
    rq  = sy ? "R4" : (hs ? "R3" : "R2");
    @(posedge clk); #1;
    sync_mode = sy; high_speed = hs; run_en = run;
    div_wr = 1'b1; div_wdata = DIV_W'(x);
    @(posedge clk); #1;
    div_wr = 1'b0;
    first_bit = -1; second_bit = -1; first_os = -1; os_cnt = 0; mism = 0;
    for (int n = 0; n < 2 * p + 1; n++) begin
      @(negedge clk);
      if (bit_tick) begin
        if (first_bit < 0) first_bit = n;
        else if (second_bit < 0) second_bit = n;
      end
      if (os_tick) begin
        if (first_os < 0) first_os = n;
        if (n < p) os_cnt++;
      end
      if (bit_tick && !os_tick) mism++;
    end
    check(first_bit == p - 1, "R5", first_bit, p - 1);
    check(first_os == osp - 1, "R5", first_os, osp - 1);
    check(second_bit == 2 * p - 1, rq, second_bit, 2 * p - 1);
    check(os_cnt == p / osp, rq, os_cnt, p / osp);
    check(mism == 0, "R8", mism, 0);
    if (!sy && !run) check(second_bit == 2 * p - 1, "R9", second_bit, 2 * p - 1);
  endtask

  initial begin
    int quiet, first_bit, second_bit;
    void'($urandom(32'h5eed_0b17));

    // R1: reset state
    quiet = 0;
    repeat (5) begin
      @(negedge clk);
      if (os_tick || bit_tick) quiet++;
    end
    check(quiet == 0, "R1", quiet, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // R2 with the exact 64x26 case
    run_trial(25, 1'b0, 1'b0, 1'b1);
    // R10: divisor end values
    run_trial(0, 1'b0, 1'b1, 1'b1);
    run_trial(0, 1'b1, 1'b0, 1'b1);
    run_trial(255, 1'b1, 1'b1, 1'b1);
    run_trial(255, 1'b0, 1'b0, 1'b0);
    // R4: speed select ignored in synchronous mode
    run_trial(7, 1'b1, 1'b0, 1'b1);
    run_trial(7, 1'b1, 1'b1, 1'b1);
    // R9: asynchronous with run enable low
    run_trial(3, 1'b0, 1'b1, 1'b0);

    for (int t = 0; t < 10; t++) begin
      int x;
      bit sy, hs, rn;
      x  = int'($urandom % 32);
      sy = 1'($urandom);
      hs = 1'($urandom);
      rn = sy ? 1'b1 : 1'($urandom);
      run_trial(x, sy, hs, rn);
    end

    // R6: synchronous idle, divisor written while idle
    @(posedge clk); #1;
    sync_mode = 1'b1; high_speed = 1'b0; run_en = 1'b0;
    div_wr = 1'b1; div_wdata = DIV_W'(3);
    @(posedge clk); #1;
    div_wr = 1'b0;
    quiet = 0;
    repeat (40) begin
      @(negedge clk);
      if (os_tick || bit_tick) quiet++;
    end
    check(quiet == 0, "R6", quiet, 0);

    // R7: start produces an edge at once, then the normal period
    @(posedge clk); #1;
    run_en = 1'b1;
    first_bit = -1; second_bit = -1;
    for (int n = 0; n < 33; n++) begin
      @(negedge clk);
      if (n == 0) check(os_tick && bit_tick, "R7", int'({os_tick, bit_tick}), 3);
      if (bit_tick) begin
        if (first_bit < 0) first_bit = n;
        else if (second_bit < 0) second_bit = n;
      end
    end
    check(second_bit == 16, "R7", second_bit, 16);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG_CYCLES, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule